// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block gathers every interrupt source of a UART controller into one sticky status word, gates that word with a software-controlled mask, and drives a single level-sensitive interrupt request. Five sources are live levels that come from the FIFOs: receive trigger reached, receive empty, receive full, transmit empty and transmit full. Five more are one-cycle pulses from the receiver and modem logic: overrun, framing error, parity error, receive timeout and modem status change.

Software changes the mask only through two strobed registers. One sets mask bits and the other removes them. The mask itself can only be read. Software acknowledges status bits by writing ones to the status register. A source that is still active sets its bit again at once, so a condition that persists cannot be lost by clearing it. The block sees only decoded write strobes with their write data. It presents the mask and the status as full bus words for readback.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Status bit positions are fixed: live level input bit k (k = 0..4: rx trigger, rx empty, rx full, tx empty, tx full) sets status bit k, and event pulse bit j (j = 0..4: overrun, framing, parity, rx timeout, modem change) sets status bit 5+j, one clock after it is sampled high.
- R2: While a live level input is high, its status bit is set on every clock, even in a cycle that also clears it. Once the level drops, the bit stays set until it is cleared.
- R3: A cycle with `mask_set_we` high ORs `wdata` bits 9:0 into the mask. Mask bits that are 0 in `wdata` are kept.
- R4: A cycle with `mask_clr_we` high clears every mask bit that is 1 in `wdata` bits 9:0. If both mask strobes are high in one cycle, the clear wins for the bits that both name.
- R5: A cycle with `stat_clr_we` high clears each status bit that is 1 in `wdata` bits 9:0. Status bits whose `wdata` bit is 0 keep their value.
- R6: If a source sets a status bit in the same cycle that a clear write names that bit, the bit ends up set.
- R7: `irq` is high exactly when the AND of the mask and the status word is non-zero. It follows the registers in the same cycle they change.
- R8: While `rst_n` is low at a clock edge, the mask and the status both become zero and `irq` is low.
- R9: Bits 31:10 of `mask_rd` and `stat_rd` always read zero. Bits 31:10 of `wdata` have no effect.
- R10: With no source active and no strobe high, the mask and the status hold their values. Reading them has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 5 | Live FIFO status levels (bit order per R1) |
| src_evt | input | 5 | One-cycle event pulses (bit order per R1) |
| mask_set_we | input | 1 | Write strobe: OR write data into the mask |
| mask_clr_we | input | 1 | Write strobe: clear the mask bits named by write data |
| stat_clr_we | input | 1 | Write strobe: clear the status bits named by write data |
| wdata | input | 32 | Write data shared by the three strobes |
| mask_rd | output | 32 | Mask readback, zero above bit 9 |
| stat_rd | output | 32 | Sticky status readback, zero above bit 9 |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: five levels, five events and a 32-bit word. That gives a 10-bit status and mask small enough to walk in full. It loads all 1024 status patterns and pairs each with a distinct mask pattern. Because a set beats a clear, one cycle can force the status to any pattern. This means the interrupt equation is checked against every status value. A long pseudo-random stretch then mixes levels, pulses, colliding strobes and full-width write data against an arithmetic model of the two registers.

// File: rtl/uart_irq_pkg.sv
// Package: shared types for the UART interrupt status/mask unit.
// Assumes nothing beyond standard packed types.
package uart_irq_pkg;

    // Decoded write strobes seen by the unit in one cycle.
    typedef struct packed {
        logic mask_set;
        logic mask_clr;
        logic stat_clr;
    } irq_wr_t;

endpackage

// File: rtl/irq_sticky_reg.sv
// Module: sticky status register with write-one-to-clear.
// Each bit is set by its source and cleared by a clear write naming it.
// A set in the same cycle as a clear wins. Assumes set_i is sampled on clk.
module irq_sticky_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_bits_i,
    output logic [W-1:0] stat_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Per-bit flop: reset, then set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_o[b] <= 1'b0;
            else if (set_i[b])
                stat_o[b] <= 1'b1;
            else if (clr_we_i && clr_bits_i[b])
                stat_o[b] <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
// Module: interrupt mask changed only through set and clear strobes.
// No direct write path exists. When both strobes name a bit, clear wins.
module irq_mask_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] bits_i,
    output logic [W-1:0] mask_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Per-bit flop: reset, then clear priority over set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_o[b] <= 1'b0;
            else if (clr_we_i && bits_i[b])
                mask_o[b] <= 1'b0;
            else if (set_we_i && bits_i[b])
                mask_o[b] <= 1'b1;
        end
    end

endmodule

// File: rtl/irq_request.sv
// Module: combines mask and status into one level request.
// Purely combinational. It assumes both inputs come from flops.
module irq_request #(
    parameter int W = 10
) (
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] stat_i,
    output logic         irq_o
);

    logic [W-1:0] pending;

    // Enabled pending sources, then the OR of them.
    always_comb begin
        pending = mask_i & stat_i;
        irq_o   = |pending;
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: UART interrupt status and mask unit (top).
// Levels occupy the low status bits and events the bits above them.
// It assumes decoded write strobes, with one shared data word.
// Unused upper register bits read as zero.
module uart_irq_ctrl #(
    parameter int N_LEVEL = 5,
    parameter int N_EVENT = 5,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LEVEL-1:0] src_lvl,
    input  logic [N_EVENT-1:0] src_evt,
    input  logic               mask_set_we,
    input  logic               mask_clr_we,
    input  logic               stat_clr_we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  mask_rd,
    output logic [DATA_W-1:0]  stat_rd,
    output logic               irq
);

    import uart_irq_pkg::*;

    localparam int N_SRC = N_LEVEL + N_EVENT;
    localparam int N_PAD = DATA_W - N_SRC;

    irq_wr_t          wr;
    logic [N_SRC-1:0] src_set;
    logic [N_SRC-1:0] wbits;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] stat_q;
    logic             unused_wdata_hi;

    // Bundle strobes, pack sources and split the write data.
    always_comb begin
        wr.mask_set     = mask_set_we;
        wr.mask_clr     = mask_clr_we;
        wr.stat_clr     = stat_clr_we;
        src_set         = {src_evt, src_lvl};
        wbits           = wdata[N_SRC-1:0];
        unused_wdata_hi = ^wdata[DATA_W-1:N_SRC];
    end

    irq_sticky_reg #(.W(N_SRC)) i_sticky (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (src_set),
        .clr_we_i   (wr.stat_clr),
        .clr_bits_i (wbits),
        .stat_o     (stat_q)
    );

    irq_mask_reg #(.W(N_SRC)) i_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we_i (wr.mask_set),
        .clr_we_i (wr.mask_clr),
        .bits_i   (wbits),
        .mask_o   (mask_q)
    );

    irq_request #(.W(N_SRC)) i_req (
        .mask_i (mask_q),
        .stat_i (stat_q),
        .irq_o  (irq)
    );

    // Zero-extend the register views to the bus width.
    always_comb begin
        mask_rd = {{N_PAD{1'b0}}, mask_q};
        stat_rd = {{N_PAD{1'b0}}, stat_q};
    end

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Checker for uart_irq_ctrl: temporal properties on its ports.
// Attached to every instance of the top module by the bind below.
module uart_irq_ctrl_chk #(
    parameter int N_LEVEL = 5,
    parameter int N_EVENT = 5,
    parameter int DATA_W  = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_LEVEL-1:0]         src_lvl,
    input logic [N_EVENT-1:0]         src_evt,
    input logic                       mask_set_we,
    input logic                       mask_clr_we,
    input logic                       stat_clr_we,
    input logic [N_LEVEL+N_EVENT-1:0] wbits,
    input logic [DATA_W-1:0]          mask_rd,
    input logic [DATA_W-1:0]          stat_rd,
    input logic                       irq
);

    localparam int N_SRC = N_LEVEL + N_EVENT;

    logic [N_SRC-1:0] src;
    assign src = {src_evt, src_lvl};

    assert_reset_clear_R8: assert property (@(posedge clk)
        $rose(rst_n) |-> (mask_rd == '0 && stat_rd == '0 && !irq));

    assert_source_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_rd[N_SRC-1:0] & $past(src)) == $past(src)));

    assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set_we && !mask_clr_we) |=>
            ((mask_rd[N_SRC-1:0] & $past(wbits)) == $past(wbits)));

    assert_mask_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_clr_we |=> ((mask_rd[N_SRC-1:0] & $past(wbits)) == '0));

    assert_stat_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr_we |=>
            ((stat_rd[N_SRC-1:0] & $past(wbits) & ~$past(src)) == '0));

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rd[DATA_W-1:N_SRC] == '0 && stat_rd[DATA_W-1:N_SRC] == '0));

    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_set_we && !mask_clr_we) |=> $stable(mask_rd));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
    .N_LEVEL (N_LEVEL),
    .N_EVENT (N_EVENT),
    .DATA_W  (DATA_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_lvl     (src_lvl),
    .src_evt     (src_evt),
    .mask_set_we (mask_set_we),
    .mask_clr_we (mask_clr_we),
    .stat_clr_we (stat_clr_we),
    .wbits       (wdata[N_LEVEL+N_EVENT-1:0]),
    .mask_rd     (mask_rd),
    .stat_rd     (stat_rd),
    .irq         (irq)
);

// File: tb/test_uart_irq_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_lvl = '0;
    logic [4:0]  src_evt = '0;
    logic        mask_set_we = 1'b0;
    logic        mask_clr_we = 1'b0;
    logic        stat_clr_we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] mask_rd;
    logic [31:0] stat_rd;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [9:0]  m_mask = '0;
    logic [9:0]  m_stat = '0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    uart_irq_ctrl i_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .src_evt(src_evt),
        .mask_set_we(mask_set_we), .mask_clr_we(mask_clr_we),
        .stat_clr_we(stat_clr_we), .wdata(wdata),
        .mask_rd(mask_rd), .stat_rd(stat_rd), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare all outputs against the model; R9 is covered by full-width compares.
    task automatic check_all(input string req);
        chk(req, "mask", mask_rd, {22'b0, m_mask});
        chk(req, "stat", stat_rd, {22'b0, m_stat});
        chk(req, "irq", {31'b0, irq}, {31'b0, |(m_mask & m_stat)});
    endtask

    // Drive one cycle at the falling edge, update the model, check after the rising edge.
    task automatic cyc(input logic [4:0] l, input logic [4:0] e, input logic se,
                       input logic ce, input logic sc, input logic [31:0] w,
                       input string req);
        @(negedge clk);
        src_lvl = l; src_evt = e;
        mask_set_we = se; mask_clr_we = ce; stat_clr_we = sc; wdata = w;
        @(posedge clk);
        m_stat = (m_stat & ~(sc ? w[9:0] : 10'h0)) | {e, l};
        m_mask = (m_mask | (se ? w[9:0] : 10'h0)) & ~(ce ? w[9:0] : 10'h0);
        #1;
        check_all(req);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL R10 watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R8: reset state with sources and strobes active.
        src_lvl = 5'h1F; src_evt = 5'h1F; mask_set_we = 1'b1; wdata = '1;
        repeat (3) @(posedge clk);
        #1;
        check_all("R8");
        @(negedge clk);
        src_lvl = '0; src_evt = '0; mask_set_we = 1'b0; wdata = '0;
        rst_n = 1'b1;

        // R1: walk each level bit, then each event bit, clearing between.
        for (int k = 0; k < 5; k++) begin
            cyc(5'(1 << k), 5'h0, 1'b0, 1'b0, 1'b0, 32'h0, "R1");
            cyc(5'h0, 5'h0, 1'b0, 1'b0, 1'b1, 32'h3FF, "R5");
        end
        for (int k = 0; k < 5; k++) begin
            cyc(5'h0, 5'(1 << k), 1'b0, 1'b0, 1'b0, 32'h0, "R1");
            cyc(5'h0, 5'h0, 1'b0, 1'b0, 1'b1, 32'h3FF, "R5");
        end

        // R2: a held level survives a clear; after it drops it stays until cleared.
        cyc(5'h08, 5'h0, 1'b0, 1'b0, 1'b1, 32'h008, "R2");
        cyc(5'h08, 5'h0, 1'b0, 1'b0, 1'b1, 32'h3FF, "R2");
        cyc(5'h00, 5'h0, 1'b0, 1'b0, 1'b0, 32'h0, "R2");
        cyc(5'h00, 5'h0, 1'b0, 1'b0, 1'b1, 32'h008, "R2");

        // R3 and R4: OR into the mask, clear selected bits, clear wins on collision.
        cyc(5'h0, 5'h0, 1'b1, 1'b0, 1'b0, 32'h0F0, "R3");
        cyc(5'h0, 5'h0, 1'b1, 1'b0, 1'b0, 32'h00F, "R3");
        cyc(5'h0, 5'h0, 1'b0, 1'b1, 1'b0, 32'h0C3, "R4");
        cyc(5'h0, 5'h0, 1'b1, 1'b1, 1'b0, 32'h300, "R4");

        // R5 and R6: partial clears; a set colliding with a clear keeps the bit.
        cyc(5'h0, 5'h1F, 1'b0, 1'b0, 1'b0, 32'h0, "R5");
        cyc(5'h0, 5'h00, 1'b0, 1'b0, 1'b1, 32'h0A0, "R5");
        cyc(5'h0, 5'h01, 1'b0, 1'b0, 1'b1, 32'h3E0, "R6");

        // R9: upper write data bits do nothing.
        cyc(5'h0, 5'h0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FC00, "R9");
        cyc(5'h0, 5'h0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, "R9");
        cyc(5'h0, 5'h0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FC00, "R9");

        // R10: idle cycles hold everything.
        for (int k = 0; k < 4; k++) cyc(5'h0, 5'h0, 1'b0, 1'b0, 1'b0, 32'h0, "R10");

        // R7: every status pattern paired with a distinct mask pattern.
        for (int s = 0; s < 1024; s++) begin
            logic [9:0] sv;
            logic [9:0] mv;
            sv = 10'(s);
            mv = 10'((s * 37) ^ 10'h155);
            cyc(sv[4:0], sv[9:5], 1'b0, 1'b1, 1'b1, 32'h3FF, "R6");
            cyc(5'h0, 5'h0, 1'b1, 1'b0, 1'b0, {22'h2A5A5A, mv}, "R7");
        end

        // Mixed pseudo-random stimulus against the model.
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] w;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            w = lfsr * 32'h9E37_79B9;
            cyc(lfsr[4:0] & lfsr[9:5], lfsr[14:10] & lfsr[19:15] & lfsr[24:20],
                lfsr[25], lfsr[26] & lfsr[27], lfsr[28], w, "R7");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule